// File: doc/BRIEF.md
# Bitmap Register-Set Operation Expander

This block turns one three-operand register instruction into a stream of element operations whose register indices come from bitmaps. It owns a bank of 32 bitmaps, each 32 bits wide, with one bit per architectural integer register. An instruction does not name registers directly. It names three bitmaps: one for the destination and one for each source. The destination bitmap's set bits, taken from the lowest index upward, give the destination registers. Each source bitmap's set bits, also in ascending order, are reused in a cycle until the source list is as long as the destination list. Every element becomes one (rd, rs1, rs2) triple on a valid/ready output. The triple marked last ends the instruction.

After reset, bitmap i holds only bit i. An instruction that nobody has reconfigured therefore expands to the single scalar operation it names. Software may write any value to a bitmap, and a read returns the value held. The read port also gives the bit count of the addressed bitmap, so software knows how many element operations a destination bitmap will schedule.

All triples of one instruction are parallel: an operand is read as it was before the instruction, even when an earlier triple writes that register. A flag on the stream states this. The three bitmaps are copied when the instruction is accepted, so bitmap writes made during an expansion do not change it. An empty destination finishes at once with no triples. An empty source with a non-empty destination finishes at once with no triples and flags the operand as illegal.

Top module: `bitmap_expander`

## Requirements
- R1: After reset, bitmap i reads back as 1<<i. A write stores any 32-bit value, and from the next cycle `csr_rdata` returns exactly that value.
- R2: `csr_rcount` equals the number of set bits in the bitmap addressed by `csr_raddr`.
- R3: An accepted instruction with non-zero bitmaps emits as many triples as the destination bitmap has set bits. `out_rd` walks those bit indices in ascending order, and the first triple is valid in the cycle after acceptance.
- R4: For element k, `out_rs1` is the (k mod n1)-th set bit of the first source bitmap, counted from index 0 upward, where n1 is that bitmap's bit count. `out_rs2` follows the same rule with the second source bitmap.
- R5: `out_last` is high only on the final triple. `done` is high for one cycle in the cycle after the final triple is taken, with `illegal` low.
- R6: While `out_valid` is high and `out_ready` is low, the triple and `out_last` stay unchanged in the next cycle.
- R7: A zero destination bitmap produces no triple. `done` is high in the cycle after acceptance, and `illegal` is low.
- R8: A zero source bitmap with a non-zero destination produces no triple. `done` and `illegal` are both high in the cycle after acceptance.
- R9: `ins_ready` is high only when no expansion is in progress. The bitmaps are copied at acceptance, so a bitmap write during an expansion does not change the triples it emits.
- R10: `out_snap` is high with every valid triple. It signals that sources are read with their values from before the instruction.
- R11: `op_count` equals the set-bit count of the most recently accepted destination bitmap, from the cycle after acceptance until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Bitmap write strobe |
| csr_waddr | input | 5 | Bitmap written |
| csr_wdata | input | 32 | Value written |
| csr_raddr | input | 5 | Bitmap read |
| csr_rdata | output | 32 | Stored value of the read bitmap |
| csr_rcount | output | 6 | Set-bit count of the read bitmap |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Block idle, instruction taken when valid |
| ins_rd_sel | input | 5 | Destination bitmap number |
| ins_rs1_sel | input | 5 | First source bitmap number |
| ins_rs2_sel | input | 5 | Second source bitmap number |
| out_valid | output | 1 | Triple present |
| out_ready | input | 1 | Consumer takes the triple |
| out_rd | output | 5 | Destination register index |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_last | output | 1 | Final triple of the instruction |
| out_snap | output | 1 | Read sources with pre-instruction values |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| illegal | output | 1 | Finished due to an empty source bitmap |
| op_count | output | 6 | Element count of the accepted instruction |

## Verification
Untouched reset bitmaps show that the expansion degenerates to the scalar triple. A five-element destination against a three-bit source and a single-bit source separates correct cyclic reuse from clamping or from stopping at the shortest list. Full and single-bit destinations test the longest and shortest streams and where `out_last` falls. Empty destination or source bitmaps check the immediate completion and the illegal flag. A bitmap rewrite during an expansion shows whether the operands were copied at acceptance. Random bitmaps under random backpressure catch ordering and hold errors that the fixed cases miss.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } mode_e;

    localparam int LANES    = 3;
    localparam int LANE_RD  = 0;
    localparam int LANE_RS1 = 1;
    localparam int LANE_RS2 = 2;

endpackage

// File: rtl/bitmap_bank.sv
module bitmap_bank #(
    parameter int NUM_MAPS = 32,
    parameter int MAP_W    = 32,
    localparam int SEL_W   = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] waddr,
    input  logic [MAP_W-1:0] wdata,
    input  logic [SEL_W-1:0] raddr,
    output logic [MAP_W-1:0] rdata,
    input  logic [SEL_W-1:0] sel_rd,
    input  logic [SEL_W-1:0] sel_rs1,
    input  logic [SEL_W-1:0] sel_rs2,
    output logic [MAP_W-1:0] map_rd,
    output logic [MAP_W-1:0] map_rs1,
    output logic [MAP_W-1:0] map_rs2
);

    logic [MAP_W-1:0] bank_d [NUM_MAPS];
    logic [MAP_W-1:0] bank_q [NUM_MAPS];

    always_comb begin
        bank_d = bank_q;
        if (we && (int'(waddr) < NUM_MAPS)) begin
            bank_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MAPS; i++) begin
                bank_q[i] <= MAP_W'(1) << (i % MAP_W);
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rdata   = (int'(raddr)   < NUM_MAPS) ? bank_q[raddr]   : '0;
        map_rd  = (int'(sel_rd)  < NUM_MAPS) ? bank_q[sel_rd]  : '0;
        map_rs1 = (int'(sel_rs1) < NUM_MAPS) ? bank_q[sel_rs1] : '0;
        map_rs2 = (int'(sel_rs2) < NUM_MAPS) ? bank_q[sel_rs2] : '0;
    end

endmodule

// File: rtl/low_bit_pick.sv
module low_bit_pick #(
    parameter int W       = 32,
    localparam int IDX_W  = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bit_tally.sv
module bit_tally #(
    parameter int W       = 32,
    localparam int CNT_W  = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < W; i++) begin
            total = total + CNT_W'(vec[i]);
        end
    end

endmodule

// File: rtl/bitmap_expander.sv
module bitmap_expander
    import bmx_pkg::*;
#(
    parameter int NUM_MAPS = 32,
    parameter int MAP_W    = 32,
    localparam int SEL_W   = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1,
    localparam int IDX_W   = (MAP_W > 1) ? $clog2(MAP_W) : 1,
    localparam int CNT_W   = $clog2(MAP_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_we,
    input  logic [SEL_W-1:0] csr_waddr,
    input  logic [MAP_W-1:0] csr_wdata,
    input  logic [SEL_W-1:0] csr_raddr,
    output logic [MAP_W-1:0] csr_rdata,
    output logic [CNT_W-1:0] csr_rcount,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [SEL_W-1:0] ins_rd_sel,
    input  logic [SEL_W-1:0] ins_rs1_sel,
    input  logic [SEL_W-1:0] ins_rs2_sel,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_rd,
    output logic [IDX_W-1:0] out_rs1,
    output logic [IDX_W-1:0] out_rs2,
    output logic             out_last,
    output logic             out_snap,
    output logic             done,
    output logic             illegal,
    output logic [CNT_W-1:0] op_count
);

    // Per-lane copy of the accepted bitmap (full) and the bits not yet used (rem).
    typedef struct packed {
        mode_e                       mode;
        logic [LANES-1:0][MAP_W-1:0] full;
        logic [LANES-1:0][MAP_W-1:0] rem;
        logic                        done;
        logic                        illegal;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [MAP_W-1:0] map_rd, map_rs1, map_rs2;
    logic [IDX_W-1:0] pick [LANES];
    logic             dest_final;

    bitmap_bank #(
        .NUM_MAPS (NUM_MAPS),
        .MAP_W    (MAP_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (csr_we),
        .waddr   (csr_waddr),
        .wdata   (csr_wdata),
        .raddr   (csr_raddr),
        .rdata   (csr_rdata),
        .sel_rd  (ins_rd_sel),
        .sel_rs1 (ins_rs1_sel),
        .sel_rs2 (ins_rs2_sel),
        .map_rd  (map_rd),
        .map_rs1 (map_rs1),
        .map_rs2 (map_rs2)
    );

    bit_tally #(.W(MAP_W)) u_csr_tally (
        .vec   (csr_rdata),
        .total (csr_rcount)
    );

    bit_tally #(.W(MAP_W)) u_op_tally (
        .vec   (ctl_q.full[LANE_RD]),
        .total (op_count)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        low_bit_pick #(.W(MAP_W)) u_pick (
            .vec (ctl_q.rem[l]),
            .idx (pick[l])
        );
    end

    // Only one destination bit left: the current triple is the final one.
    assign dest_final = ((ctl_q.rem[LANE_RD] & (ctl_q.rem[LANE_RD] - MAP_W'(1))) == '0);

    always_comb begin
        logic [MAP_W-1:0] stripped;
        stripped     = '0;
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.illegal = 1'b0;
        unique case (ctl_q.mode)
            ST_IDLE: begin
                if (ins_valid) begin
                    ctl_d.full[LANE_RD]  = map_rd;
                    ctl_d.full[LANE_RS1] = map_rs1;
                    ctl_d.full[LANE_RS2] = map_rs2;
                    ctl_d.rem[LANE_RD]   = map_rd;
                    ctl_d.rem[LANE_RS1]  = map_rs1;
                    ctl_d.rem[LANE_RS2]  = map_rs2;
                    if (map_rd == '0) begin
                        ctl_d.done = 1'b1;
                    end else if ((map_rs1 == '0) || (map_rs2 == '0)) begin
                        ctl_d.done    = 1'b1;
                        ctl_d.illegal = 1'b1;
                    end else begin
                        ctl_d.mode = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    ctl_d.rem[LANE_RD] = ctl_q.rem[LANE_RD] & (ctl_q.rem[LANE_RD] - MAP_W'(1));
                    for (int l = LANE_RS1; l < LANES; l++) begin
                        stripped = ctl_q.rem[l] & (ctl_q.rem[l] - MAP_W'(1));
                        // A source list that runs out starts over from its lowest bit.
                        ctl_d.rem[l] = (stripped == '0) ? ctl_q.full[l] : stripped;
                    end
                    if (dest_final) begin
                        ctl_d.mode = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: ctl_d.mode = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ins_ready = (ctl_q.mode == ST_IDLE);
        out_valid = (ctl_q.mode == ST_EMIT);
        out_rd    = pick[LANE_RD];
        out_rs1   = pick[LANE_RS1];
        out_rs2   = pick[LANE_RS2];
        out_last  = out_valid && dest_final;
        out_snap  = out_valid;
        done      = ctl_q.done;
        illegal   = ctl_q.illegal;
    end

endmodule

// File: rtl/bmx_checker.sv
module bmx_checker #(
    parameter int NUM_MAPS = 32,
    parameter int MAP_W    = 32,
    localparam int IDX_W   = (MAP_W > 1) ? $clog2(MAP_W) : 1,
    localparam int CNT_W   = $clog2(MAP_W + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_rd,
    input logic [IDX_W-1:0] out_rs1,
    input logic [IDX_W-1:0] out_rs2,
    input logic             out_last,
    input logic             out_snap,
    input logic             done,
    input logic             illegal,
    input logic [CNT_W-1:0] op_count
);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rd) && $stable(out_rs1)
                                    && $stable(out_rs2) && $stable(out_last));

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !ins_ready);

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> done && !illegal && ins_ready && !out_valid);

    p_illegal_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !out_valid);

    p_snap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_snap);

    p_count_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> op_count != '0);

endmodule

bind bitmap_expander bmx_checker #(
    .NUM_MAPS (NUM_MAPS),
    .MAP_W    (MAP_W)
) u_bmx_checker (.*);

// File: tb/test_bitmap_expander.sv
module test_bitmap_expander;

    localparam int NM = 32;
    localparam int MW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [4:0]  csr_waddr = '0;
    logic [31:0] csr_wdata = '0;
    logic [4:0]  csr_raddr = '0;
    logic [31:0] csr_rdata;
    logic [5:0]  csr_rcount;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [4:0]  ins_rd_sel = '0, ins_rs1_sel = '0, ins_rs2_sel = '0;
    logic        out_valid;
    logic        out_ready;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic        out_last, out_snap, done, illegal;
    logic [5:0]  op_count;

    always #10 clk = ~clk;

    bitmap_expander i_bitmap_expander (.*);

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] mbank [NM];
    int q_rd[$], q_s1[$], q_s2[$];
    bit mon_on = 0;
    bit bp_on  = 0;
    bit pop_pending = 0;
    bit stalled = 0;
    logic [4:0] prev_rd, prev_s1, prev_s2;
    logic prev_last;

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int pc(logic [31:0] v);
        int n = 0;
        for (int i = 0; i < 32; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // Cycle-by-cycle comparison against the expected triple queue
    initial out_ready = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (pop_pending && q_rd.size() > 0) begin
                void'(q_rd.pop_front());
                void'(q_s1.pop_front());
                void'(q_s2.pop_front());
            end
            if (q_rd.size() > 0) begin
                check(out_valid == 1'b1, "R3", "out_valid while triples pending", out_valid, 1);
                check(ins_ready == 1'b0, "R9", "ins_ready during expansion", ins_ready, 0);
                if (out_valid) begin
                    check(int'(out_rd) == q_rd[0], "R3", "out_rd", out_rd, q_rd[0]);
                    check(int'(out_rs1) == q_s1[0], "R4", "out_rs1", out_rs1, q_s1[0]);
                    check(int'(out_rs2) == q_s2[0], "R4", "out_rs2", out_rs2, q_s2[0]);
                    check(out_last == (q_rd.size() == 1), "R5", "out_last", out_last, q_rd.size() == 1);
                    check(out_snap == 1'b1, "R10", "out_snap", out_snap, 1);
                    if (stalled) begin
                        check(out_rd == prev_rd && out_rs1 == prev_s1 && out_rs2 == prev_s2
                              && out_last == prev_last, "R6", "triple changed under stall",
                              {out_rd, out_rs1, out_rs2}, {prev_rd, prev_s1, prev_s2});
                    end
                end
            end else begin
                check(out_valid == 1'b0, "R3", "out_valid with nothing pending", out_valid, 0);
            end
            out_ready   = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
            pop_pending = out_valid && out_ready;
            stalled     = out_valid && !out_ready;
            prev_rd = out_rd; prev_s1 = out_rs1; prev_s2 = out_rs2; prev_last = out_last;
        end
    end

    task automatic csr_write(int a, logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_waddr = 5'(a); csr_wdata = v;
        @(posedge clk);
        #1;
        csr_we = 1'b0;
        mbank[a] = v;
    endtask

    task automatic csr_read_check(int a);
        @(negedge clk);
        csr_raddr = 5'(a);
        #1;
        check(csr_rdata == mbank[a], "R1", "csr_rdata", csr_rdata, mbank[a]);
        check(int'(csr_rcount) == pc(mbank[a]), "R2", "csr_rcount", csr_rcount, pc(mbank[a]));
    endtask

    task automatic issue(int rd, int a, int b);
        logic [31:0] d = mbank[rd];
        logic [31:0] s1 = mbank[a];
        logic [31:0] s2 = mbank[b];
        int dl[$], l1[$], l2[$];
        bit zero_d, bad;
        int guard = 0;
        for (int i = 0; i < 32; i++) begin
            if (d[i])  dl.push_back(i);
            if (s1[i]) l1.push_back(i);
            if (s2[i]) l2.push_back(i);
        end
        zero_d = (d == 0);
        bad    = !zero_d && (s1 == 0 || s2 == 0);
        @(negedge clk);
        while (!ins_ready) @(negedge clk);
        ins_valid = 1'b1;
        ins_rd_sel = 5'(rd); ins_rs1_sel = 5'(a); ins_rs2_sel = 5'(b);
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
        if (!zero_d && !bad) begin
            for (int k = 0; k < dl.size(); k++) begin
                q_rd.push_back(dl[k]);
                q_s1.push_back(l1[k % l1.size()]);
                q_s2.push_back(l2[k % l2.size()]);
            end
        end
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 4000);
        #2;
        if (zero_d) begin
            check(guard == 1 && done, "R7", "done delay for empty destination", guard, 1);
            check(illegal == 1'b0, "R7", "illegal for empty destination", illegal, 0);
        end else if (bad) begin
            check(guard == 1 && done, "R8", "done delay for empty source", guard, 1);
            check(illegal == 1'b1, "R8", "illegal for empty source", illegal, 1);
        end else begin
            check(done == 1'b1, "R5", "done after final triple", done, 1);
            check(illegal == 1'b0, "R5", "illegal after normal finish", illegal, 0);
        end
        check(q_rd.size() == 0, "R3", "triples left over", q_rd.size(), 0);
        check(int'(op_count) == dl.size(), "R11", "op_count", op_count, dl.size());
        @(negedge clk);
        check(done == 1'b0, "R5", "done lasts one cycle", done, 0);
    endtask

    function automatic logic [31:0] rand_map(int kind);
        case (kind)
            0: return 32'hFFFF_FFFF;
            1: return 32'h1 << $urandom_range(0, 31);
            2: return 32'h0;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < NM; i++) mbank[i] = 32'h1 << i;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(ins_ready == 1'b1, "R9", "ins_ready after reset", ins_ready, 1);
        check(out_valid == 1'b0, "R3", "out_valid after reset", out_valid, 0);
        check(done == 1'b0, "R5", "done after reset", done, 0);
        mon_on = 1;

        // R1/R2: reset contents
        for (int i = 0; i < NM; i++) csr_read_check(i);

        // Untouched bitmaps give the scalar triple
        issue(1, 2, 3);

        // Wraparound: five destinations, three-bit and one-bit sources, with backpressure
        bp_on = 1;
        csr_write(1, 32'b011111);
        csr_write(2, 32'b1011);
        csr_write(3, 32'b00010);
        csr_read_check(1);
        issue(1, 2, 3);

        // All-ones destination against single-bit and all-ones sources
        csr_write(4, 32'hFFFF_FFFF);
        csr_write(5, 32'h8000_0000);
        issue(4, 5, 4);
        // Single-bit destination at the top index
        issue(5, 4, 2);

        // R7: empty destination, R8: empty sources
        csr_write(6, 32'h0);
        csr_read_check(6);
        issue(6, 1, 2);
        issue(1, 6, 2);
        issue(1, 2, 6);

        // R9: bitmap writes during an expansion leave it unchanged
        fork
            issue(4, 2, 3);
            begin
                repeat (4) @(negedge clk);
                csr_write(4, 32'h0000_0F00);
                csr_write(2, 32'h0);
            end
        join
        csr_read_check(4);
        csr_read_check(2);
        issue(4, 3, 1);

        // Random bitmaps
        for (int t = 0; t < 60; t++) begin
            int rd = $urandom_range(0, 31);
            int a  = $urandom_range(0, 31);
            int b  = $urandom_range(0, 31);
            csr_write(rd, rand_map($urandom_range(0, 12) == 0 ? 2 : $urandom_range(0, 5)));
            if (a != rd) csr_write(a, rand_map($urandom_range(0, 12) == 0 ? 2 : $urandom_range(0, 5)));
            if (b != rd && b != a) csr_write(b, rand_map($urandom_range(0, 12) == 0 ? 2 : $urandom_range(0, 5)));
            csr_read_check(rd);
            issue(rd, a, b);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule